// File: doc/BRIEF.md
# Reassociated Feedback Accumulator

This block keeps a running sum of a stream of signed samples. Each accepted sample adds its own value plus a signed offset to the total, so the total obeys y_i = y_{i-1} + x_i + a. Addition may be regrouped freely, so the block computes the offset sum (x_i + a) one cycle ahead in a registered pre-stage. The loop-carried path from the total register back to its own input then holds a single adder.

A sample is offered with a valid strobe and the offset beside it. The offset is normally held constant by a configuration register upstream. The total changes one clock edge after the pre-stage has captured a sample, and a one-cycle strobe marks each change. A clear input zeroes the total. It also drops the sample held in the pre-stage, but any sample offered in the same cycle as the clear is kept and becomes the first term of the new sum. The block accepts a new sample on every cycle with no gaps.

Top module: `reassoc_acc`

## Requirements
- R1: While `rst_n` is low and after it rises, before any sample, `acc_y` is 0 and `acc_valid` is 0.
- R2: A sample accepted at clock edge k (`in_valid` high, `clear` low at edge k and k+1) makes `acc_y` after edge k+1 equal to its previous value plus sign-extended `in_x` plus sign-extended `in_a`, both as sampled at edge k.
- R3: `acc_valid` is high for exactly the cycle after an edge where the total was updated, and low after any edge where it was not.
- R4: If no sample is held in the pre-stage and `clear` is low, `acc_y` is unchanged at the next edge.
- R5: Samples accepted at consecutive edges each produce their own update at consecutive edges, so one sample per cycle is sustained.
- R6: `acc_y` is a 24-bit two's complement value that wraps modulo 2^24 with no saturation.
- R7: `clear` high at an edge sets `acc_y` to 0 and discards the sample held in the pre-stage; `acc_valid` is 0 after that edge.
- R8: A sample offered with `in_valid` high at the same edge as `clear` is accepted and updates the new, zeroed total at the following edge.
- R9: `in_x` and `in_a` are 16-bit two's complement values; negative values, including -32768, subtract from the total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Zero the total and drop the pre-stage sample |
| in_valid | input | 1 | Qualifies `in_x` and `in_a` in this cycle |
| in_x | input | 16 | Signed sample |
| in_a | input | 16 | Signed offset added with each sample |
| acc_y | output | 24 | Signed running total |
| acc_valid | output | 1 | Pulses for one cycle when `acc_y` has just changed by a sample |

## Verification
A table of mixed samples runs first. It has positive, negative and most-negative operands, gaps in the valid strobe, and a clear that lands together with a sample. Each result is compared against an independent model, so a wrong extension, a lost or doubled update, or a wrong clear rule shows up. A long unbroken run of maximum-size samples pushes the total past 2^23 and checks sustained throughput as well as modulo wrap. Directed idle stretches confirm the total holds when nothing is in flight. A clear issued while a sample sits in the pre-stage confirms that this sample is discarded and not added to the new sum.

// File: rtl/reassoc_acc_pkg.sv
package reassoc_acc_pkg;
  localparam int DEF_X_W = 16;
  localparam int DEF_Y_W = 24;
endpackage

// File: rtl/reassoc_pre_stage.sv
module reassoc_pre_stage #(
  parameter int X_W = reassoc_acc_pkg::DEF_X_W,
  parameter int Y_W = reassoc_acc_pkg::DEF_Y_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [X_W-1:0] in_x,
  input  logic [X_W-1:0] in_a,
  output logic           pre_vld,
  output logic [Y_W-1:0] pre_sum
);
  localparam int EXT_W = Y_W - X_W;

  // widen a signed operand to the total's width
  function automatic logic [Y_W-1:0] widen(input logic [X_W-1:0] v);
    return {{EXT_W{v[X_W-1]}}, v};
  endfunction

  // feed-forward term: independent of earlier iterations
  function automatic logic [Y_W-1:0] offset_sum(input logic [X_W-1:0] x,
                                                input logic [X_W-1:0] a);
    return widen(x) + widen(a);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_vld <= 1'b0;
      pre_sum <= '0;
    end else begin
      pre_vld <= in_valid;
      if (in_valid) pre_sum <= offset_sum(in_x, in_a);
    end
  end
endmodule

// File: rtl/reassoc_loop.sv
module reassoc_loop #(
  parameter int Y_W = reassoc_acc_pkg::DEF_Y_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           pre_vld,
  input  logic [Y_W-1:0] pre_sum,
  output logic [Y_W-1:0] acc_y,
  output logic           acc_valid
);
  // one adder between the total register output and its input
  function automatic logic [Y_W-1:0] loop_add(input logic [Y_W-1:0] y,
                                              input logic [Y_W-1:0] t);
    return y + t;
  endfunction

  logic upd_w;
  assign upd_w = pre_vld & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_y     <= '0;
      acc_valid <= 1'b0;
    end else begin
      acc_valid <= upd_w;
      if (clear)      acc_y <= '0;
      else if (upd_w) acc_y <= loop_add(acc_y, pre_sum);
    end
  end
endmodule

// File: rtl/reassoc_acc.sv
module reassoc_acc #(
  parameter int X_W = reassoc_acc_pkg::DEF_X_W,
  parameter int Y_W = reassoc_acc_pkg::DEF_Y_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           in_valid,
  input  logic [X_W-1:0] in_x,
  input  logic [X_W-1:0] in_a,
  output logic [Y_W-1:0] acc_y,
  output logic           acc_valid
);
  logic           pre_vld_w;
  logic [Y_W-1:0] pre_sum_w;

  reassoc_pre_stage #(.X_W(X_W), .Y_W(Y_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_x     (in_x),
    .in_a     (in_a),
    .pre_vld  (pre_vld_w),
    .pre_sum  (pre_sum_w)
  );

  reassoc_loop #(.Y_W(Y_W)) u_loop (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .pre_vld   (pre_vld_w),
    .pre_sum   (pre_sum_w),
    .acc_y     (acc_y),
    .acc_valid (acc_valid)
  );
endmodule

// File: rtl/reassoc_acc_chk.sv
module reassoc_acc_chk #(
  parameter int Y_W = reassoc_acc_pkg::DEF_Y_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clear,
  input logic           in_valid,
  input logic           pre_vld,
  input logic [Y_W-1:0] pre_sum,
  input logic [Y_W-1:0] acc_y,
  input logic           acc_valid
);
  always_comb begin
    if (!rst_n) begin
      a_rst_r1: assert (acc_y == '0 && !acc_valid);
    end
  end

  p_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_vld && !clear) |=> acc_y == Y_W'($past(acc_y) + $past(pre_sum)));

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_vld && !clear) |=> acc_valid);

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_vld || clear) |=> !acc_valid);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_vld && !clear) |=> $stable(acc_y));

  p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> pre_vld);

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc_y == '0);

  p_clear_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && in_valid) |=> pre_vld);
endmodule

bind reassoc_acc reassoc_acc_chk #(.Y_W(Y_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear     (clear),
  .in_valid  (in_valid),
  .pre_vld   (pre_vld_w),
  .pre_sum   (pre_sum_w),
  .acc_y     (acc_y),
  .acc_valid (acc_valid)
);

// File: tb/reassoc_acc_bench.sv
`timescale 1ns/1ps
module reassoc_acc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_x = '0;
  logic [15:0] in_a = '0;
  logic [23:0] acc_y;
  logic        acc_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  logic [23:0] m_y = '0;
  logic        m_v = 1'b0;
  logic        m_pv = 1'b0;
  logic [23:0] m_ps = '0;

  always #2 clk = ~clk;

  reassoc_acc u_reassoc_acc (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_x(in_x), .in_a(in_a), .acc_y(acc_y), .acc_valid(acc_valid)
  );

  // {valid, clear, x, a}
  localparam logic [33:0] VEC [12] = '{
    {1'b1, 1'b0, 16'h0005, 16'h0003},
    {1'b1, 1'b0, 16'hFFF6, 16'h0003},
    {1'b1, 1'b0, 16'h0064, 16'hFFFF},
    {1'b0, 1'b0, 16'h1234, 16'h0003},
    {1'b1, 1'b0, 16'h8000, 16'h8000},
    {1'b1, 1'b0, 16'h7FFF, 16'h0000},
    {1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b1, 1'b1, 16'h0001, 16'h0002},
    {1'b1, 1'b0, 16'h0002, 16'h0002},
    {1'b0, 1'b1, 16'h0000, 16'h0000},
    {1'b0, 1'b0, 16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ext(input logic [15:0] v);
    return {{8{v[15]}}, v};
  endfunction

  // drive one cycle, advance the model, compare after the edge
  task automatic step(input logic v, input logic c, input logic [15:0] x,
                      input logic [15:0] a, input string tag);
    @(negedge clk);
    in_valid = v; clear = c; in_x = x; in_a = a;
    @(posedge clk);
    #1;
    if (c) begin
      m_y = '0; m_v = 1'b0;
    end else if (m_pv) begin
      m_y = m_y + m_ps; m_v = 1'b1;
    end else begin
      m_v = 1'b0;
    end
    m_pv = v;
    if (v) m_ps = ext(x) + ext(a);
    chk({tag, " y"}, acc_y, m_y);
    chk({tag, " valid"}, {23'd0, acc_valid}, {23'd0, m_v});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset y", acc_y, 24'd0);
    chk("R1 reset valid", {23'd0, acc_valid}, 24'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 16'h0, 16'h0, "R1 idle after reset");

    // table walk: R2 R5 R9 R8 R7 R3
    foreach (VEC[i]) begin
      step(VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0], "R2/R9 table");
    end

    // R4: idle cycles leave the total alone
    step(1'b1, 1'b0, 16'h0010, 16'h0001, "R2 load");
    step(1'b0, 1'b0, 16'h0, 16'h0, "R2 apply");
    chk("R2 value 17", acc_y, 24'd17);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 16'hABCD, 16'h1111, "R4 hold");
    chk("R4 still 17", acc_y, 24'd17);

    // R7: sample in flight when clear arrives is dropped
    step(1'b1, 1'b0, 16'h0100, 16'h0000, "R7 in flight");
    step(1'b0, 1'b1, 16'h0, 16'h0, "R7 clear");
    step(1'b0, 1'b0, 16'h0, 16'h0, "R7 after");
    chk("R7 dropped", acc_y, 24'd0);

    // R8: sample together with clear starts new sum
    step(1'b1, 1'b1, 16'h0009, 16'h0001, "R8 clear+sample");
    step(1'b0, 1'b0, 16'h0, 16'h0, "R8 apply");
    chk("R8 new sum", acc_y, 24'd10);
    chk("R3 pulse", {23'd0, acc_valid}, 24'd1);
    step(1'b0, 1'b0, 16'h0, 16'h0, "R3 pulse end");
    chk("R3 low again", {23'd0, acc_valid}, 24'd0);

    // R5 + R6: unbroken max samples, wraps past 2^24
    step(1'b0, 1'b1, 16'h0, 16'h0, "R6 clear");
    for (int k = 0; k < 300; k++) step(1'b1, 1'b0, 16'h7FFF, 16'h7FFF, "R5/R6 run");
    step(1'b0, 1'b0, 16'h0, 16'h0, "R6 drain");
    chk("R6 wrapped total", acc_y, 24'(300 * 65534));

    finish_run();
  end
endmodule